// File: doc/BRIEF.md
# Command Ring Pointer Engine

This block is the controller side of an outbound command ring. A host register port fills a 256-entry RAM of 32-bit command words. The host owns the write pointer, and the hardware owns the read pointer. While fetching is enabled, the engine moves the read pointer forward through the ring. It presents each pending command to a codec link on a valid/ready pair, one command per cycle at most.

Fetching requires three things: the run bit is set, the ring size field holds the code for 256 entries, and the read pointer is not held in reset. The read pointer resets through a two-phase handshake. Software sets the reset bit and sees it read back as set. Software then clears it and sees zero before normal use.

A power input marks the block as usable. While it is low, every register read returns all ones, host writes are dropped and nothing goes out on the link.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset, the write-pointer, read-pointer, control and size registers all read 0, and `cmd_valid_o` is low.
- R2: A host write with `reg_addr_i[8]`=1 stores `reg_wdata_i` in ring entry `reg_addr_i[7:0]`. A read at the same address returns that entry.
- R3: The size register is at address 3, in bits 1:0. Only the value 2 (256 entries) enables fetching, and with any other value no command is issued.
- R4: Writing the read-pointer register (address 1) with bit 15 set forces the read index to 0. From the next cycle bit 15 reads back as 1 and no command is issued. Writing it with bit 15 clear ends the reset, and the register then reads 0.
- R5: The engine presents entry (RP+1) mod 256 on `cmd_data_o` with `cmd_valid_o` high when all of these hold: run (address 2, bit 0) is set, the size is 2, no reset is in progress and WP (address 0, bits 7:0) differs from RP. Each cycle with valid and ready high advances RP by one, so RP equals WP once the ring is drained.
- R6: `cmd_addr_o` carries bits 31:28 of the command being presented.
- R7: While valid is high and `cmd_ready_i` is low, the command and RP hold.
- R8: After run is cleared, a command already presented stays valid until it is taken. The run bit reads back 1 until then and 0 afterwards, and no further command is fetched.
- R9: A write to WP whose value equals RP while WP differs from RP would overrun the ring. It is ignored, and WP keeps its value.
- R10: While `pwr_on_i` is low, every register read returns 0xFFFFFFFF, host writes have no effect and `cmd_valid_o` is low.
- R11: Read and write indices wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_i | input | 1 | Block powered and accessible |
| reg_we_i | input | 1 | Host write strobe |
| reg_addr_i | input | 9 | Host address: bit 8 selects the ring window, bits 7:0 the register or the entry |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| cmd_valid_o | output | 1 | Command presented to the link |
| cmd_ready_i | input | 1 | Link accepts the command |
| cmd_data_o | output | 32 | Command word |
| cmd_addr_o | output | 4 | Target codec address field of the command |

## Verification
The bench fills the whole ring and then drains it past index 255. A design that wraps wrongly would stick at 255 or send stale entries. It stalls the link, then clears run during the stall. A design that drops valid early, or that keeps fetching after the stall ends, is caught by the run readback and the final read index.

It writes WP equal to RP while one entry is pending. A design without the overrun guard would silently empty the ring. It also enters the read-pointer reset while commands are pending. It checks that the index stays at 0 and that issue stays blocked until bit 15 is cleared. Finally, it removes power with a command pending and confirms that valid drops, that reads return all ones and that writes made during that time do not appear.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;
  localparam int REG_WP       = 0;
  localparam int REG_RP       = 1;
  localparam int REG_CTL      = 2;
  localparam int REG_SIZE     = 3;
  localparam int RP_RST_BIT   = 15;
  localparam int CTL_RUN_BIT  = 0;
  localparam int SIZE_W       = 2;
  localparam int SIZE_CODE256 = 2;
endpackage

// File: rtl/cmdring_mem.sv
module cmdring_mem #(
  parameter  int IDX_W  = 8,
  parameter  int DATA_W = 32,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]  ridx_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/cmdring_regs.sv
module cmdring_regs
  import cmdring_pkg::*;
#(
  parameter  int IDX_W  = 8,
  parameter  int DATA_W = 32,
  localparam int RA_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic              we_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [IDX_W-1:0]  rp_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [IDX_W-1:0]  wp_o,
  output logic              rp_clr_o,
  output logic              rp_rst_o,
  output logic              run_o,
  output logic              size_ok_o
);
  logic [IDX_W-1:0]  wp_q;
  logic              rst_q, run_q;
  logic [SIZE_W-1:0] size_q;
  logic              win, acc, wp_we, rp_we, ctl_we, size_we, overrun;
  logic [IDX_W-1:0]  idx, wp_val;

  assign win     = addr_i[IDX_W];
  assign idx     = addr_i[IDX_W-1:0];
  assign acc     = we_i && pwr_on_i;
  assign wp_we   = acc && !win && (idx == IDX_W'(REG_WP));
  assign rp_we   = acc && !win && (idx == IDX_W'(REG_RP));
  assign ctl_we  = acc && !win && (idx == IDX_W'(REG_CTL));
  assign size_we = acc && !win && (idx == IDX_W'(REG_SIZE));
  assign wp_val  = wdata_i[IDX_W-1:0];
  // moving WP onto RP from a non-empty ring would swallow every pending entry
  assign overrun = (wp_val == rp_i) && (wp_val != wp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rst_q  <= 1'b0;
      run_q  <= 1'b0;
      size_q <= '0;
    end else begin
      if (wp_we && !overrun) wp_q <= wp_val;
      if (rp_we)   rst_q  <= wdata_i[RP_RST_BIT];
      if (ctl_we)  run_q  <= wdata_i[CTL_RUN_BIT];
      if (size_we) size_q <= wdata_i[SIZE_W-1:0];
    end
  end

  assign mem_we_o  = acc && win;
  assign idx_o     = idx;
  assign wp_o      = wp_q;
  assign rp_clr_o  = rp_we && wdata_i[RP_RST_BIT];
  assign rp_rst_o  = rst_q;
  assign run_o     = run_q;
  assign size_ok_o = (size_q == SIZE_W'(SIZE_CODE256));

  always_comb begin
    rdata_o = '0;
    if (!pwr_on_i) begin
      rdata_o = '1;
    end else if (win) begin
      rdata_o = mem_rdata_i;
    end else begin
      case (idx)
        IDX_W'(REG_WP): rdata_o[IDX_W-1:0] = wp_q;
        IDX_W'(REG_RP): begin
          rdata_o[IDX_W-1:0]  = rp_i;
          rdata_o[RP_RST_BIT] = rst_q;
        end
        IDX_W'(REG_CTL):  rdata_o[CTL_RUN_BIT] = run_q | hold_i;
        IDX_W'(REG_SIZE): rdata_o[SIZE_W-1:0]  = size_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assert_overrun_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_we && overrun) |=> $stable(wp_q));
endmodule

// File: rtl/cmdring_fetch.sv
module cmdring_fetch #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int CA_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic              run_i,
  input  logic              size_ok_i,
  input  logic              rp_rst_i,
  input  logic              rp_clr_i,
  input  logic [IDX_W-1:0]  wp_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  output logic [IDX_W-1:0]  rp_o,
  output logic              hold_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [CA_W-1:0]   cmd_addr_o
);
  logic [IDX_W-1:0] rp_q;
  logic             hold_q, pending, fetch_en, fire;

  assign pending  = (rp_q != wp_i);
  assign fetch_en = run_i && size_ok_i;
  // a presented command stays up after run drops, until the link takes it
  assign cmd_valid_o = pwr_on_i && !rp_rst_i && pending && (fetch_en || hold_q);
  assign fire        = cmd_valid_o && cmd_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rp_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= cmd_valid_o && !cmd_ready_i;
      if (rp_clr_i)  rp_q <= '0;
      else if (fire) rp_q <= rp_q + 1'b1;
    end
  end

  assign rd_idx_o   = rp_q + 1'b1;
  assign cmd_data_o = rd_data_i;
  assign cmd_addr_o = rd_data_i[DATA_W-1 -: CA_W];
  assign rp_o       = rp_q;
  assign hold_o     = hold_q;

  assert_stall_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && !cmd_ready_i && !rp_clr_i) |=> $stable(rp_q));
  assert_advance_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !rp_clr_i) |=> (rp_q == $past(rp_q) + 1'b1));
  assert_not_empty_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (rp_q != wp_i));
  assert_wrap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !rp_clr_i && (rp_q == '1)) |=> (rp_q == '0));
endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine #(
  parameter  int IDX_W  = 8,
  parameter  int DATA_W = 32,
  parameter  int CA_W   = 4,
  localparam int RA_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_on_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic [CA_W-1:0]   cmd_addr_o
);
  logic [IDX_W-1:0]  rp, wp, rd_idx, host_idx;
  logic              hold, mem_we, rp_clr, rp_rst, run, size_ok;
  logic [DATA_W-1:0] rd_data, host_rdata;

  cmdring_regs #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .rp_i       (rp),
    .hold_i     (hold),
    .mem_rdata_i(host_rdata),
    .mem_we_o   (mem_we),
    .idx_o      (host_idx),
    .wp_o       (wp),
    .rp_clr_o   (rp_clr),
    .rp_rst_o   (rp_rst),
    .run_o      (run),
    .size_ok_o  (size_ok)
  );

  cmdring_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk_i    (clk_i),
    .we_i     (mem_we),
    .widx_i   (host_idx),
    .wdata_i  (reg_wdata_i),
    .ridx_a_i (rd_idx),
    .rdata_a_o(rd_data),
    .ridx_b_i (host_idx),
    .rdata_b_o(host_rdata)
  );

  cmdring_fetch #(.IDX_W(IDX_W), .DATA_W(DATA_W), .CA_W(CA_W)) u_fetch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pwr_on_i   (pwr_on_i),
    .run_i      (run),
    .size_ok_i  (size_ok),
    .rp_rst_i   (rp_rst),
    .rp_clr_i   (rp_clr),
    .wp_i       (wp),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .rp_o       (rp),
    .hold_o     (hold),
    .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i),
    .cmd_data_o (cmd_data_o),
    .cmd_addr_o (cmd_addr_o)
  );

  assert_reset_blocks_issue_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rp_rst |-> !cmd_valid_o);
  assert_idle_after_stop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !hold) |-> !cmd_valid_o);
endmodule

// File: tb/tb_cmd_ring_engine.sv
module tb_cmd_ring_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwr_on_i = 1'b1;
  logic        reg_we_i = 1'b0;
  logic [8:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        cmd_ready_i = 1'b0;
  logic [31:0] reg_rdata_o, cmd_data_o;
  logic        cmd_valid_o;
  logic [3:0]  cmd_addr_o;

  always #4 clk_i = ~clk_i;

  cmd_ring_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_on_i(pwr_on_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_data_o(cmd_data_o), .cmd_addr_o(cmd_addr_o)
  );

  int    checks = 0;
  int    fails = 0;
  int    cyc = 0;
  string phase = "R1";

  // behavioural model state
  int          m_wp, m_rp, m_size, rp_old, v;
  bit          m_rst, m_run, m_hold, ev;
  logic [31:0] m_mem [256];
  logic [31:0] ed, er;

  function automatic logic [31:0] pat(input int i);
    return (32'(i) * 32'h9E37_79B1) ^ 32'h00A5_5A00;
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 60000) begin
      fails++;
      $display("FAIL %s watchdog expired: actual hung, expected finish", phase);
      report();
      $finish;
    end
  end

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      m_wp = 0; m_rp = 0; m_size = 0; m_rst = 0; m_run = 0; m_hold = 0;
    end else begin
      ev = pwr_on_i && !m_rst && (m_rp != m_wp) && ((m_run && m_size == 2) || m_hold);
      ed = m_mem[(m_rp + 1) % 256];
      if (!pwr_on_i) er = '1;
      else if (reg_addr_i[8]) er = m_mem[reg_addr_i[7:0]];
      else case (int'(reg_addr_i[7:0]))
        0: er = 32'(m_wp);
        1: er = (m_rst ? 32'h8000 : 32'h0) | 32'(m_rp);
        2: er = {31'b0, m_run || m_hold};
        3: er = 32'(m_size);
        default: er = '0;
      endcase
      checks++;
      if (cmd_valid_o !== ev) begin
        fails++;
        $display("FAIL %s cmd_valid_o actual %b expected %b", phase, cmd_valid_o, ev);
      end
      if (ev) begin
        checks += 2;
        if (cmd_data_o !== ed) begin
          fails++;
          $display("FAIL %s R5 cmd_data_o actual %h expected %h", phase, cmd_data_o, ed);
        end
        if (cmd_addr_o !== ed[31:28]) begin
          fails++;
          $display("FAIL %s R6 cmd_addr_o actual %h expected %h", phase, cmd_addr_o, ed[31:28]);
        end
      end
      checks++;
      if (reg_rdata_o !== er) begin
        fails++;
        $display("FAIL %s reg_rdata_o actual %h expected %h", phase, reg_rdata_o, er);
      end
      // advance as the coming rising edge will
      rp_old = m_rp;
      if (ev && cmd_ready_i) m_rp = (m_rp + 1) % 256;
      if (pwr_on_i && reg_we_i) begin
        if (reg_addr_i[8]) m_mem[reg_addr_i[7:0]] = reg_wdata_i;
        else case (int'(reg_addr_i[7:0]))
          0: begin
            v = int'(reg_wdata_i[7:0]);
            if (!(v == rp_old && v != m_wp)) m_wp = v;
          end
          1: begin
            m_rst = reg_wdata_i[15];
            if (reg_wdata_i[15]) m_rp = 0;
          end
          2: m_run = reg_wdata_i[0];
          3: m_size = int'(reg_wdata_i[1:0]);
          default: ;
        endcase
      end
      m_hold = ev && !cmd_ready_i;
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(posedge clk_i); #2;
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #2;
    reg_we_i = 1'b0;
  endtask

  task automatic chk(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(posedge clk_i); #2;
    reg_addr_i = a;
    @(negedge clk_i); #1;
    checks++;
    if (reg_rdata_o !== e) begin
      fails++;
      $display("FAIL %s read %h actual %h expected %h", tag, a, reg_rdata_o, e);
    end
  endtask

  task automatic rdy(input logic b);
    @(posedge clk_i); #2;
    cmd_ready_i = b;
  endtask

  task automatic pwr(input logic b);
    @(posedge clk_i); #2;
    pwr_on_i = b;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;

    phase = "R1";
    chk(9'h000, 32'h0, "R1");
    chk(9'h001, 32'h0, "R1");
    chk(9'h002, 32'h0, "R1");
    chk(9'h003, 32'h0, "R1");

    phase = "R2";
    for (int i = 0; i < 256; i++) wr({1'b1, 8'(i)}, pat(i));
    chk(9'h103, pat(3), "R2");
    chk(9'h1FF, pat(255), "R2");

    phase = "R4";
    wr(9'h003, 32'h2);
    wr(9'h001, 32'h8000);
    chk(9'h001, 32'h8000, "R4");
    wr(9'h001, 32'h0);
    chk(9'h001, 32'h0, "R4");

    phase = "R5";
    rdy(1'b1);
    wr(9'h002, 32'h1);
    wr(9'h000, 32'h5);
    wait_cyc(10);
    chk(9'h001, 32'h5, "R5");
    chk(9'h000, 32'h5, "R5");

    phase = "R7";
    rdy(1'b0);
    wr(9'h000, 32'h7);
    wait_cyc(3);
    @(negedge clk_i); #1;
    checks++;
    if (!(cmd_valid_o === 1'b1 && cmd_addr_o === pat(6)[31:28])) begin
      fails++;
      $display("FAIL R6 stalled addr actual %h expected %h", cmd_addr_o, pat(6)[31:28]);
    end

    phase = "R8";
    wr(9'h002, 32'h0);
    chk(9'h002, 32'h1, "R8");
    rdy(1'b1);
    wait_cyc(3);
    chk(9'h002, 32'h0, "R8");
    chk(9'h001, 32'h6, "R8");

    phase = "R9";
    wr(9'h000, 32'h6);
    chk(9'h000, 32'h7, "R9");
    wr(9'h002, 32'h1);
    wait_cyc(4);
    chk(9'h001, 32'h7, "R9");

    phase = "R3";
    wr(9'h003, 32'h1);
    wr(9'h000, 32'h9);
    wait_cyc(5);
    chk(9'h001, 32'h7, "R3");
    wr(9'h003, 32'h2);
    wait_cyc(5);
    chk(9'h001, 32'h9, "R3");

    phase = "R11";
    wr(9'h000, 32'd200);
    wait_cyc(200);
    chk(9'h001, 32'd200, "R11");
    wr(9'h000, 32'd255);
    wait_cyc(60);
    wr(9'h000, 32'd3);
    wait_cyc(10);
    chk(9'h001, 32'd3, "R11");

    phase = "R4";
    rdy(1'b0);
    wr(9'h000, 32'd10);
    wr(9'h001, 32'h8000);
    chk(9'h001, 32'h8000, "R4");
    rdy(1'b1);
    wait_cyc(4);
    chk(9'h001, 32'h8000, "R4");
    rdy(1'b0);
    wr(9'h001, 32'h0);
    chk(9'h001, 32'h0, "R4");
    rdy(1'b1);
    wait_cyc(15);
    chk(9'h001, 32'd10, "R4");

    phase = "R10";
    rdy(1'b0);
    wr(9'h000, 32'd12);
    pwr(1'b0);
    chk(9'h000, 32'hFFFF_FFFF, "R10");
    wr(9'h000, 32'd20);
    wr(9'h132, 32'h0);
    pwr(1'b1);
    chk(9'h000, 32'd12, "R10");
    chk(9'h132, pat(50), "R10");
    rdy(1'b1);
    wait_cyc(6);
    chk(9'h001, 32'd12, "R10");

    report();
    $finish;
  end
endmodule